// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Patcher

This block applies symbol corrections to a page buffer held in a byte-wide RAM. The page holds 2112 bytes: 2048 payload bytes at addresses 0 to 2047, followed by 64 spare bytes at addresses 2048 to 2111. An external decoder locates the errors. For each error it hands the block a 12-bit symbol index and a 12-bit error value. The code symbols are 12 bits wide and are packed across byte boundaries. So a correction normally touches two neighbouring bytes, and the split of the error value depends on whether the index is odd or even.

Each accepted correction becomes one or two read-modify-write XOR operations on the RAM. Every byte operation takes a read cycle and then a write cycle. A page is a run of corrections whose final entry carries a last marker. Once that entry has been handled, the block pulses a done signal and reports the number of corrections it applied, together with a sticky failure flag. The flag is raised by indices that cannot be patched, by a pattern that does not fit index 0, and by a page that holds more corrections than the correction budget.

Top module: `rs_sym_patcher`

## Requirements
- R1: While reset is asserted and right after it, `fix_ready` is 1, neither RAM strobe is active, and `page_done`, `page_fail` and `page_fixes` are all 0.
- R2: An odd index p (1 to 1365) XORs byte floor(3p/2) with bits [11:4] of the pattern, then byte floor(3p/2)+1 with bits [3:0] of the pattern placed in bits [7:4].
- R3: An even nonzero index p XORs byte 3p/2-1 with bits [11:8] of the pattern (zero-extended), then byte 3p/2 with bits [7:0] of the pattern.
- R4: Index 0 XORs only byte 0, with bits [7:0] of the pattern, and only if bits [11:8] of the pattern are zero. Otherwise the correction writes nothing and marks the page failed.
- R5: Index 1365 patches payload byte 2047 (pattern bits [11:4]) and spare byte 0 at address 2048 (pattern bits [3:0] shifted up by four).
- R6: Indices 1366 to 1374 land in the spare area under the same odd/even rule, with addresses from 2048 to 2061.
- R7: An index above 1374 writes nothing and marks the page failed.
- R8: A page applies at most 4 corrections. A further correction writes nothing and marks the page failed, and `page_fixes` reports the number applied.
- R9: Once the page is marked failed, the flag stays set and later corrections in that page write nothing.
- R10: Each byte write goes to the address read in the previous cycle, with the read data XOR the patch byte. `fix_ready` is low while a correction is being applied. `page_done` is high for the cycle following the final write of the last correction, or the cycle following acceptance of a last correction that writes nothing.
- R11: The first correction accepted after a page ends clears the count and the failure flag before it is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_valid | input | 1 | Correction offered |
| fix_ready | output | 1 | Block can take a correction |
| fix_pos | input | 12 | Symbol index |
| fix_pat | input | 12 | Error value to XOR in |
| fix_last | input | 1 | Final correction of the page |
| ram_addr | output | 12 | RAM byte address |
| ram_rd_en | output | 1 | RAM read strobe, data returned one cycle later |
| ram_rdata | input | 8 | RAM read data |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| page_done | output | 1 | One-cycle pulse when the page has been handled |
| page_fail | output | 1 | Page could not be fully corrected |
| page_fixes | output | 3 | Corrections applied to the page |

## Verification
A correction accepted on clock edge E produces a read in the next cycle and the matching write one cycle after that. The second byte follows the same pair, so a correction that needs k byte operations finishes on edge E+2k, and the done pulse, count and flag are visible just after that edge. The driver derives k from its own model of the mapping rules. It waits exactly 2k falling edges after the handshake before it samples the page results, and it checks the cycle after that for the end of the pulse. A monitor checks every RAM write, in order and at the falling edge, against the queue of expected address and data pairs, and it flags any write that arrives when the queue is empty. At the end, the whole RAM image is compared with the bench's shadow copy.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int SYM_W       = 12;
    localparam int BYTE_W      = 8;
    localparam int HEAD_W      = SYM_W - BYTE_W;
    localparam int DATA_BYTES  = 2048;
    localparam int SPARE_BYTES = 64;
    localparam int TOTAL_BYTES = DATA_BYTES + SPARE_BYTES;
    localparam int ADDR_W      = $clog2(TOTAL_BYTES);
    localparam int LAST_POS    = 1374;

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Byte-level view of one correction
    typedef struct packed {
        logic  bad;   // cannot be patched
        logic  two;   // touches two bytes
        addr_t a0;
        addr_t a1;
        byte_t v0;
        byte_t v1;
    } fix_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_WR0,
        ST_RD1,
        ST_WR1
    } eng_st_e;

endpackage

// File: rtl/rsp_pos_map.sv
module rsp_pos_map
    import rsp_pkg::*;
(
    input  sym_t pos,
    input  sym_t pat,
    output fix_t fx
);

    logic [ADDR_W:0] half_w;
    logic [ADDR_W:0] lo_w;
    logic [ADDR_W:0] hi_w;
    logic            odd;
    logic            too_far;

    always_comb begin
        odd     = pos[0];
        // floor(3p/2) = p + floor(p/2)
        half_w  = (ADDR_W+1)'(pos) + (ADDR_W+1)'(pos >> 1);
        lo_w    = odd ? half_w : half_w - 1'b1;
        hi_w    = lo_w + 1'b1;
        too_far = (pos > SYM_W'(LAST_POS)) || (hi_w >= (ADDR_W+1)'(TOTAL_BYTES));

        fx.bad  = too_far;
        fx.two  = 1'b1;
        fx.a0   = lo_w[ADDR_W-1:0];
        fx.a1   = hi_w[ADDR_W-1:0];
        if (odd) begin
            fx.v0 = pat[SYM_W-1:HEAD_W];
            fx.v1 = {pat[HEAD_W-1:0], {(BYTE_W-HEAD_W){1'b0}}};
        end else begin
            fx.v0 = BYTE_W'(pat[SYM_W-1:BYTE_W]);
            fx.v1 = pat[BYTE_W-1:0];
        end

        if (pos == '0) begin
            // symbol 0 only carries eight real bits
            fx.bad = |pat[SYM_W-1:BYTE_W];
            fx.two = 1'b0;
            fx.a0  = '0;
            fx.v0  = pat[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/rsp_rmw_engine.sv
module rsp_rmw_engine
    import rsp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    two,
    input  addr_t   a0,
    input  addr_t   a1,
    input  byte_t   v0,
    input  byte_t   v1,
    output logic    busy,
    output logic    fin,
    output addr_t   ram_addr,
    output logic    ram_rd_en,
    input  byte_t   ram_rdata,
    output logic    ram_wr_en,
    output byte_t   ram_wdata
);

    typedef struct packed {
        eng_st_e st;
        logic    two;
        addr_t   a0;
        addr_t   a1;
        byte_t   v0;
        byte_t   v1;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d     = eng_q;
        ram_rd_en = 1'b0;
        ram_wr_en = 1'b0;
        ram_addr  = eng_q.a0;
        ram_wdata = ram_rdata ^ eng_q.v0;
        fin       = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    eng_d.st  = ST_RD0;
                    eng_d.two = two;
                    eng_d.a0  = a0;
                    eng_d.a1  = a1;
                    eng_d.v0  = v0;
                    eng_d.v1  = v1;
                end
            end
            ST_RD0: begin
                ram_rd_en = 1'b1;
                eng_d.st  = ST_WR0;
            end
            ST_WR0: begin
                ram_wr_en = 1'b1;
                if (eng_q.two) begin
                    eng_d.st = ST_RD1;
                end else begin
                    eng_d.st = ST_IDLE;
                    fin      = 1'b1;
                end
            end
            ST_RD1: begin
                ram_rd_en = 1'b1;
                ram_addr  = eng_q.a1;
                eng_d.st  = ST_WR1;
            end
            ST_WR1: begin
                ram_wr_en = 1'b1;
                ram_addr  = eng_q.a1;
                ram_wdata = ram_rdata ^ eng_q.v1;
                eng_d.st  = ST_IDLE;
                fin       = 1'b1;
            end
            default: eng_d.st = ST_IDLE;
        endcase
        busy = (eng_q.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, two: 1'b0, a0: '0, a1: '0, v0: '0, v1: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    // R10: a write always follows a read of the same byte
    a_r10_wr_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> ($past(ram_rd_en) && ($past(ram_addr) == ram_addr)));

    // R6: every access stays inside the page buffer
    a_r6_addr_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd_en || ram_wr_en) |-> (ram_addr < ADDR_W'(TOTAL_BYTES)));

endmodule

// File: rtl/rsp_page_track.sv
module rsp_page_track #(
    parameter  int MAX_CORR = 4,
    localparam int CNT_W    = $clog2(MAX_CORR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             offer,
    input  logic             bad,
    input  logic             last,
    input  logic             fin,
    output logic             grant,
    output logic [CNT_W-1:0] count,
    output logic             fail,
    output logic             done
);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
        logic             fail;
        logic             done;
        logic             pend_last;
    } trk_t;

    trk_t             trk_d, trk_q;
    logic [CNT_W-1:0] base_cnt;
    logic             base_fail;

    always_comb begin
        // R11: a fresh page starts from a clean slate
        base_cnt  = trk_q.open ? trk_q.cnt : '0;
        base_fail = trk_q.open && trk_q.fail;
        grant     = !bad && !base_fail && (base_cnt < CNT_W'(MAX_CORR));

        trk_d      = trk_q;
        trk_d.done = 1'b0;
        if (offer) begin
            trk_d.open = !last;
            trk_d.cnt  = base_cnt + CNT_W'(grant);
            trk_d.fail = base_fail || !grant;
            if (grant) begin
                trk_d.pend_last = last;
            end else begin
                trk_d.done = last;
            end
        end
        if (fin) begin
            trk_d.done      = trk_q.pend_last;
            trk_d.pend_last = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign count = trk_q.cnt;
    assign fail  = trk_q.fail;
    assign done  = trk_q.done;

    // R8: the applied count never exceeds the budget
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_CORR));

    // R9: the failure flag only drops when a new correction is taken
    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail) |-> $past(offer));

    // R11: the count moves only on an accepted correction
    a_r11_count_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> $past(offer));

endmodule

// File: rtl/rs_sym_patcher.sv
module rs_sym_patcher
    import rsp_pkg::*;
#(
    parameter  int MAX_CORR = 4,
    localparam int CNT_W    = $clog2(MAX_CORR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fix_valid,
    output logic              fix_ready,
    input  logic [SYM_W-1:0]  fix_pos,
    input  logic [SYM_W-1:0]  fix_pat,
    input  logic              fix_last,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd_en,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic              ram_wr_en,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic              page_done,
    output logic              page_fail,
    output logic [CNT_W-1:0]  page_fixes
);

    fix_t fx;
    logic busy;
    logic fin;
    logic offer;
    logic grant;

    rsp_pos_map u_map (
        .pos (fix_pos),
        .pat (fix_pat),
        .fx  (fx)
    );

    assign fix_ready = !busy;
    assign offer     = fix_valid && fix_ready;

    rsp_page_track #(
        .MAX_CORR (MAX_CORR)
    ) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .offer (offer),
        .bad   (fx.bad),
        .last  (fix_last),
        .fin   (fin),
        .grant (grant),
        .count (page_fixes),
        .fail  (page_fail),
        .done  (page_done)
    );

    rsp_rmw_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (offer && grant),
        .two       (fx.two),
        .a0        (fx.a0),
        .a1        (fx.a1),
        .v0        (fx.v0),
        .v1        (fx.v1),
        .busy      (busy),
        .fin       (fin),
        .ram_addr  (ram_addr),
        .ram_rd_en (ram_rd_en),
        .ram_rdata (ram_rdata),
        .ram_wr_en (ram_wr_en),
        .ram_wdata (ram_wdata)
    );

    // R10: no new correction is taken while RAM traffic is in flight
    a_r10_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd_en || ram_wr_en) |-> !fix_ready);

    // R10: the done pulse appears only with the engine idle
    a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> fix_ready);

endmodule

// File: tb/rs_sym_patcher_tb.sv
`timescale 1ns/1ps
module rs_sym_patcher_tb_top;

    localparam int TOT = 2112;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fix_valid = 1'b0;
    logic        fix_ready;
    logic [11:0] fix_pos = '0;
    logic [11:0] fix_pat = '0;
    logic        fix_last = 1'b0;
    logic [11:0] ram_addr;
    logic        ram_rd_en;
    logic [7:0]  ram_rdata;
    logic        ram_wr_en;
    logic [7:0]  ram_wdata;
    logic        page_done;
    logic        page_fail;
    logic [2:0]  page_fixes;

    always #4 clk = ~clk;

    rs_sym_patcher dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fix_valid  (fix_valid),
        .fix_ready  (fix_ready),
        .fix_pos    (fix_pos),
        .fix_pat    (fix_pat),
        .fix_last   (fix_last),
        .ram_addr   (ram_addr),
        .ram_rd_en  (ram_rd_en),
        .ram_rdata  (ram_rdata),
        .ram_wr_en  (ram_wr_en),
        .ram_wdata  (ram_wdata),
        .page_done  (page_done),
        .page_fail  (page_fail),
        .page_fixes (page_fixes)
    );

    // Page RAM model, one-cycle read latency
    logic [7:0] mem [0:TOT-1];
    logic [7:0] shadow [0:TOT-1];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOT; i++) mem[i] <= 8'(i * 37 + 11);
            ram_rdata <= '0;
        end else begin
            if (ram_wr_en) mem[ram_addr] <= ram_wdata;
            if (ram_rd_en) ram_rdata <= mem[ram_addr];
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard of expected RAM writes
    typedef struct {
        int a;
        int d;
        string req;
    } wr_item_t;
    wr_item_t exp_q[$];

    logic        prev_rd = 1'b0;
    logic [11:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n && ram_wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected write addr", int'(ram_addr), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(int'(ram_addr) == it.a, it.req, "write addr", int'(ram_addr), it.a);
                chk(int'(ram_wdata) == it.d, it.req, "write data", int'(ram_wdata), it.d);
                chk(prev_rd && prev_addr == ram_addr, "R10", "read before write",
                    int'(prev_addr), int'(ram_addr));
            end
        end
        prev_rd   = ram_rd_en;
        prev_addr = ram_addr;
    end

    // Bench model of page state
    bit m_open = 1'b0;
    int m_cnt = 0;
    bit m_fail = 1'b0;

    task automatic send(input int pos, input int pat, input bit last, input string req);
        int a[2];
        int v[2];
        int n;
        bit bad;
        bit grant;
        int base_c;
        bit base_f;
        n = 0;
        bad = 1'b0;
        a[0] = 0; a[1] = 0; v[0] = 0; v[1] = 0;
        if (pos == 0) begin
            if ((pat >> 8) != 0) bad = 1'b1;
            else begin n = 1; a[0] = 0; v[0] = pat & 255; end
        end else if (pos > 1374) begin
            bad = 1'b1;
        end else if (pos % 2 == 1) begin
            n = 2; a[0] = (3 * pos) / 2; v[0] = (pat >> 4) & 255;
            a[1] = a[0] + 1; v[1] = (pat << 4) & 255;
        end else begin
            n = 2; a[0] = (3 * pos) / 2 - 1; v[0] = pat >> 8;
            a[1] = (3 * pos) / 2; v[1] = pat & 255;
        end
        base_c = m_open ? m_cnt : 0;
        base_f = m_open && m_fail;
        grant  = !bad && !base_f && (base_c < 4);
        m_open = !last;
        m_cnt  = base_c + int'(grant);
        m_fail = base_f || !grant;
        if (!grant) n = 0;
        for (int i = 0; i < n; i++) begin
            wr_item_t it;
            shadow[a[i]] = shadow[a[i]] ^ 8'(v[i]);
            it.a = a[i];
            it.d = int'(shadow[a[i]]);
            it.req = req;
            exp_q.push_back(it);
        end
        @(negedge clk);
        while (!fix_ready) @(negedge clk);
        fix_valid = 1'b1;
        fix_pos   = 12'(pos);
        fix_pat   = 12'(pat);
        fix_last  = last;
        @(negedge clk);
        fix_valid = 1'b0;
        fix_last  = 1'b0;
        if (n > 0) chk(!fix_ready, "R10", "ready low while busy", int'(fix_ready), 0);
        if (last) begin
            repeat (2 * n) @(negedge clk);
            chk(page_done == 1'b1, "R10", "done due", int'(page_done), 1);
            chk(page_fail == m_fail, req, "page fail", int'(page_fail), int'(m_fail));
            chk(int'(page_fixes) == m_cnt, req, "page fixes", int'(page_fixes), m_cnt);
            chk(exp_q.size() == 0, req, "writes drained", exp_q.size(), 0);
            @(negedge clk);
            chk(page_done == 1'b0, "R10", "done one cycle", int'(page_done), 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bad_bytes;
        for (int i = 0; i < TOT; i++) shadow[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(fix_ready == 1'b1, "R1", "ready in reset", int'(fix_ready), 1);
        chk(!ram_rd_en && !ram_wr_en, "R1", "ram idle in reset",
            int'({ram_rd_en, ram_wr_en}), 0);
        chk(page_done == 1'b0 && page_fail == 1'b0, "R1", "flags in reset",
            int'({page_done, page_fail}), 0);
        chk(page_fixes == 3'd0, "R1", "fixes in reset", int'(page_fixes), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fix_ready == 1'b1 && !ram_wr_en, "R1", "idle after reset",
            int'({fix_ready, ram_wr_en}), 2);

        // Page A: odd, even, index 0, boundary index
        send(5, 'hABC, 1'b0, "R2");
        send(10, 'h123, 1'b0, "R3");
        send(0, 'h0FF, 1'b0, "R4");
        send(1365, 'hFED, 1'b1, "R5");

        // Page B: spare area
        send(1366, 'h5A5, 1'b0, "R6");
        send(1373, 'h3C3, 1'b0, "R6");
        send(1374, 'hFFF, 1'b1, "R6");

        // Page C: out of range, then a later good one is dropped
        send(1375, 'h111, 1'b0, "R7");
        send(7, 'h777, 1'b1, "R9");

        // Page D: index 0 with upper bits set
        send(0, 'h100, 1'b1, "R4");

        // Page E: budget exceeded
        send(2, 'h0A1, 1'b0, "R8");
        send(4, 'hB02, 1'b0, "R8");
        send(6, 'h3C4, 1'b0, "R8");
        send(8, 'hDD5, 1'b0, "R8");
        send(9, 'h6E6, 1'b1, "R8");

        // Page F: flags cleared by the next page
        send(3, 'h00F, 1'b1, "R11");

        // Page G: far out of range
        send(4095, 'hFFF, 1'b1, "R7");

        // Page H: same symbol twice cancels out
        send(11, 'h800, 1'b0, "R10");
        send(11, 'h800, 1'b1, "R10");

        repeat (4) @(negedge clk);
        bad_bytes = 0;
        for (int i = 0; i < TOT; i++) if (mem[i] !== shadow[i]) bad_bytes++;
        chk(bad_bytes == 0, "R2", "final page image mismatches", bad_bytes, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule